// File: doc/BRIEF.md
# Overriding Two-Speed Branch Target Predictor

This block sits in the fetch stage. Each cycle it takes the current fetch address and, in the same cycle, offers a guess for the next fetch address. The guess comes from a small direct-mapped table of recently seen taken-path targets. Each entry holds an address tag, a target and the last outcome of the branch. A second, slower predictor uses 2-bit saturating counters. Its verdict on the same lookup is ready a fixed two cycles later.

While the slow verdict is pending, fetch carries on with sequential blocks. Some lookups hit in the table, were guessed not taken by the fast path, and are then judged taken by the slow counter. For each of these the block raises a redirect, steers fetch to the stored target and counts one early clear. The sequential blocks fetched in the meantime are discarded, and they cannot cause a redirect of their own.

An update port from later pipeline stages writes resolved branches into both tables.

Top module: `bpo_predictor_top`

## Requirements
- R1: After reset every fast-table entry is empty, every slow counter holds 2'b01 (weakly not taken), `early_clears` is 0 and `redirect` is 0.
- R2: The fast table has 64 direct-mapped entries. The entry is selected by fetch_pc[9:4] and the tag is fetch_pc[31:10]. A lookup hits only on a valid entry with a matching tag, so an address with the same index and a different tag misses.
- R3: In the cycle of a lookup, `pred_taken` is 1 exactly when the lookup hits an entry whose last outcome was taken, and then `next_pc` is the stored target. Otherwise `next_pc` is fetch_pc + 16, unless a redirect is active.
- R4: An update writes the tag, target and outcome of `upd_pc` at the next clock edge. A lookup in the same cycle as the update still sees the old contents.
- R5: The slow counter is selected by pc[11:4] (256 counters). It moves up on a taken update, saturating at 3, and down on a not-taken update, saturating at 0. A counter value of 2 or 3 means taken.
- R6: When a valid lookup at cycle t hits, is guessed not taken by the fast path, and its slow counter means taken, then `redirect` is 1 in cycle t+2 and `next_pc` in that cycle is the target read at cycle t. This overrides the fast guess of cycle t+2.
- R7: No redirect follows a lookup that missed, or a lookup that the fast path already predicted taken.
- R8: A redirect discards the lookups of its own cycle and of the cycle before. Neither of them can cause a redirect, so two redirects never occur in consecutive cycles.
- R9: `early_clears` increases by exactly 1 in the cycle after each redirect and is otherwise unchanged. It wraps at its width.
- R10: A cycle with `fetch_valid` low starts no lookup that can later redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch lookup is made this cycle |
| fetch_pc | input | 32 | Address of the fetch block being looked up |
| next_pc | output | 32 | Address to fetch next |
| pred_taken | output | 1 | Fast-path guess of taken for this lookup |
| redirect | output | 1 | Slow predictor overrides fetch this cycle (early clear) |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved taken-path target |
| upd_taken | input | 1 | Resolved outcome |
| early_clears | output | 16 | Count of early redirects |

## Verification
`pred_taken` and the sequential or table `next_pc` are due in the lookup cycle itself. `redirect` and the target it carries are due two cycles after the lookup. The counter step shows one cycle after the redirect. Table writes become visible to lookups one edge after the update. The bench holds a two-deep queue of pending lookup records that shifts once per clock, and it reads the expected redirect from the oldest record. Inputs are driven at the falling edge and every output is compared a nanosecond later, so each comparison falls inside the cycle in which that result is due.

// File: rtl/bpo_pkg.sv
package bpo_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = ctr_t'(1);

  // saturating step of a confidence counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == '1) ? c : ctr_t'(c + 1'b1);
    return (c == '0) ? c : ctr_t'(c - 1'b1);
  endfunction

  // upper half of the counter range votes taken
  function automatic logic ctr_taken(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/bpo_fast_table.sv
module bpo_fast_table #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 4,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_last_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - OFF_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] last_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  assign lk_idx = idx_of(lk_pc);
  assign wr_idx = idx_of(upd_pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      vld_q[wr_idx]  <= 1'b1;
      last_q[wr_idx] <= upd_taken;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[wr_idx] <= tag_of(upd_pc);
      tgt_q[wr_idx] <= upd_target;
    end
  end

  assign lk_hit        = vld_q[lk_idx] && (tag_q[lk_idx] == tag_of(lk_pc));
  assign lk_last_taken = last_q[lk_idx];
  assign lk_target     = tgt_q[lk_idx];

  // R4: a written entry becomes valid with the written outcome on the next edge
  a_r4_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (vld_q[$past(wr_idx)] && (last_q[$past(wr_idx)] == $past(upd_taken))));
endmodule

// File: rtl/bpo_slow_ctr.sv
module bpo_slow_ctr
  import bpo_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 4,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];
  logic [IDX_W-1:0] lk_idx, wr_idx;
  ctr_t wr_cur;

  assign lk_idx = lk_pc[OFF_W +: IDX_W];
  assign wr_idx = upd_pc[OFF_W +: IDX_W];
  assign wr_cur = ctr_q[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      ctr_q[wr_idx] <= ctr_step(wr_cur, upd_taken);
    end
  end

  assign lk_taken = ctr_taken(ctr_q[lk_idx]);

  // R5: saturation at both ends
  a_r5_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && (wr_cur == '1)) |=> (ctr_q[$past(wr_idx)] == '1));
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && (wr_cur == '0)) |=> (ctr_q[$past(wr_idx)] == '0));
endmodule

// File: rtl/bpo_override_pipe.sv
module bpo_override_pipe #(
  parameter int PC_W  = 32,
  parameter int LAT   = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_hit,
  input  logic             in_fast_taken,
  input  logic             in_slow_taken,
  input  logic [PC_W-1:0]  in_target,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [CNT_W-1:0] early_clears
);
  localparam int LAST = LAT - 1;

  logic [LAT-1:0]  v_q, hit_q, fast_q, slow_q;
  logic [PC_W-1:0] tgt_q [LAT];
  logic [CNT_W-1:0] clr_q;

  // override event: slow votes taken where fetch went sequential
  assign redirect    = v_q[LAST] && hit_q[LAST] && !fast_q[LAST] && slow_q[LAST];
  assign redirect_pc = tgt_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_valid && !redirect;
      for (int k = 1; k < LAT; k++) v_q[k] <= v_q[k-1] && !redirect;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      fast_q <= '0;
      slow_q <= '0;
    end else begin
      hit_q[0]  <= in_hit;
      fast_q[0] <= in_fast_taken;
      slow_q[0] <= in_slow_taken;
      for (int k = 1; k < LAT; k++) begin
        hit_q[k]  <= hit_q[k-1];
        fast_q[k] <= fast_q[k-1];
        slow_q[k] <= slow_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    tgt_q[0] <= in_target;
    for (int k = 1; k < LAT; k++) tgt_q[k] <= tgt_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clr_q <= '0;
    else if (redirect) clr_q <= clr_q + 1'b1;
  end
  assign early_clears = clr_q;

  // R8: the younger lookups are squashed, so no redirect follows a redirect
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);
  // R9: counter steps by one per redirect, holds otherwise
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (early_clears == CNT_W'($past(early_clears) + 1'b1)));
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> $stable(early_clears));
endmodule

// File: rtl/bpo_predictor_top.sv
module bpo_predictor_top #(
  parameter int PC_W       = 32,
  parameter int BLK_BYTES  = 16,
  parameter int FAST_IDX_W = 6,
  parameter int SLOW_IDX_W = 8,
  parameter int SLOW_LAT   = 2,
  parameter int CLR_CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic [PC_W-1:0]      fetch_pc,
  output logic [PC_W-1:0]      next_pc,
  output logic                 pred_taken,
  output logic                 redirect,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic [PC_W-1:0]      upd_target,
  input  logic                 upd_taken,
  output logic [CLR_CNT_W-1:0] early_clears
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(BLK_BYTES);
  endfunction

  logic            f_hit, f_last, slow_vote, fast_taken;
  logic [PC_W-1:0] f_target, rd_pc;

  bpo_fast_table #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(FAST_IDX_W)) u_fast (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(fetch_pc), .lk_hit(f_hit), .lk_last_taken(f_last), .lk_target(f_target),
    .upd_en(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
  );

  bpo_slow_ctr #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(SLOW_IDX_W)) u_slow (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(fetch_pc), .lk_taken(slow_vote),
    .upd_en(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  assign fast_taken = f_hit && f_last;

  bpo_override_pipe #(.PC_W(PC_W), .LAT(SLOW_LAT), .CNT_W(CLR_CNT_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(fetch_valid), .in_hit(f_hit), .in_fast_taken(fast_taken),
    .in_slow_taken(slow_vote), .in_target(f_target),
    .redirect(redirect), .redirect_pc(rd_pc), .early_clears(early_clears)
  );

  assign pred_taken = fast_taken;
  assign next_pc    = redirect ? rd_pc : (fast_taken ? f_target : seq_next(fetch_pc));

  // R3: a fast-taken guess never leaves fetch sequential unless overridden
  a_r3_taken_leaves_line: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken && !redirect) |-> (next_pc == f_target));
endmodule

// File: tb/bpo_predictor_top_test.sv
module bpo_predictor_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        pred_taken, redirect;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic        upd_taken = 1'b0;
  logic [15:0] early_clears;

  always #2 clk = ~clk;

  bpo_predictor_top uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .next_pc(next_pc), .pred_taken(pred_taken), .redirect(redirect),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .early_clears(early_clears)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference state
  bit          m_v   [64];
  bit          m_h   [64];
  int unsigned m_tag [64];
  logic [31:0] m_tgt [64];
  int          m_c   [256];
  typedef struct { bit v; bit hit; bit h; int c; logic [31:0] t; } rec_t;
  rec_t        pend[$];
  logic [15:0] m_clr;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_h[i] = 0; m_tag[i] = 0; m_tgt[i] = '0; end
    for (int i = 0; i < 256; i++) m_c[i] = 1;
    pend.delete();
    pend.push_back('{0, 0, 0, 0, '0});
    pend.push_back('{0, 0, 0, 0, '0});
    m_clr = '0;
  endtask

  task automatic cyc(input bit fv, input logic [31:0] pc,
                     input bit uv, input logic [31:0] upc, input logic [31:0] utg, input bit utk);
    int fi, si, ui, usi;
    bit hit, ft, exp_rd;
    logic [31:0] exp_np;
    rec_t old;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc;
    upd_valid = uv; upd_pc = upc; upd_target = utg; upd_taken = utk;
    #1;
    fi = int'(pc[9:4]); si = int'(pc[11:4]);
    hit = m_v[fi] && (m_tag[fi] == pc[31:10]);
    ft = hit && m_h[fi];
    old = pend[0];
    exp_rd = old.v && old.hit && !old.h && (old.c >= 2);
    exp_np = exp_rd ? old.t : (ft ? m_tgt[fi] : pc + 32'd16);
    check("redirect (R6 R7 R8 R10)", {31'd0, redirect}, {31'd0, exp_rd});
    check("pred_taken (R3)", {31'd0, pred_taken}, {31'd0, ft});
    check("next_pc (R3 R6)", next_pc, exp_np);
    check("early_clears (R9)", {16'd0, early_clears}, {16'd0, m_clr});
    @(posedge clk);
    if (exp_rd) begin m_clr = m_clr + 16'd1; pend[1].v = 0; end
    void'(pend.pop_front());
    pend.push_back('{fv && !exp_rd, hit, m_h[fi], m_c[si], m_tgt[fi]});
    if (uv) begin
      ui = int'(upc[9:4]); usi = int'(upc[11:4]);
      m_v[ui] = 1; m_h[ui] = utk; m_tag[ui] = upc[31:10]; m_tgt[ui] = utg;
      if (utk) m_c[usi] = (m_c[usi] == 3) ? 3 : m_c[usi] + 1;
      else     m_c[usi] = (m_c[usi] == 0) ? 0 : m_c[usi] - 1;
    end
  endtask

  task automatic look(input logic [31:0] pc);
    cyc(1, pc, 0, '0, '0, 0);
  endtask
  task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input bit tk);
    cyc(0, 32'h0000_F000, 1, pc, tg, tk);
  endtask

  localparam logic [31:0] A  = 32'h0000_1230;
  localparam logic [31:0] TA = 32'h0000_4000;
  localparam logic [31:0] A2 = 32'h0000_1630; // same fast index, other tag

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty tables, weak counters, zero count
    cur_req = "R1";
    for (int i = 0; i < 8; i++) look(32'h0000_0100 * i);
    // R4: update with same-cycle lookup sees old contents
    cur_req = "R4";
    cyc(1, A, 1, A, TA, 1);
    look(A);
    // R2: alias with same index misses
    cur_req = "R2";
    look(A2); look(A2 + 32'h10);
    // R5 R6: saturate to 3 then one not-taken leaves 2 with last outcome not taken
    cur_req = "R5 R6";
    upd(A, TA, 1); upd(A, TA, 1); upd(A, TA, 1); upd(A, TA, 0);
    look(A); look(A + 32'h10); look(A + 32'h20); look(A + 32'h30);
    // R8: back-to-back lookups of the same branch
    cur_req = "R8";
    look(A); look(A); look(A); look(A); look(A); look(A);
    // R10: no lookup when fetch_valid is low
    cur_req = "R10";
    cyc(0, A, 0, '0, '0, 0); look(32'h40); look(32'h50); look(32'h60);
    // R7: fast already taken, and miss, produce no redirect
    cur_req = "R7";
    upd(A, TA, 1);
    look(A); look(A2); look(32'h70); look(32'h80);
    // R5: drain to zero then no redirect
    cur_req = "R5";
    repeat (5) upd(A, TA, 0);
    look(A); look(32'h90); look(32'hA0);
    // mixed random traffic
    cur_req = "R3 R6 R9";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p;
      logic [31:0] q;
      p = {20'd0, 2'($urandom_range(0, 3)), 2'd0, 3'($urandom_range(0, 7)), 5'd0};
      q = {20'd0, 2'($urandom_range(0, 3)), 2'd0, 3'($urandom_range(0, 7)), 5'd0};
      cyc(($urandom_range(0, 7) != 0), p, ($urandom_range(0, 2) == 0), q,
          32'h0001_0000 + ($urandom_range(0, 255) << 4), ($urandom_range(0, 2) != 0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule